// File: doc/BRIEF.md
# Dual Heartbeat Watchdog

This block holds two independent watchdog timers for a system of four nodes with thirty-two hardware threads each. Each timer reloads from a programmed maximum and counts down to zero; reaching zero is a wrap. Each timer has a 128-bit participation mask. Every thread selected in that mask must report in during each period by writing its own thread index to the timer's heartbeat command register. A wrap at which some selected thread has not reported counts as a missed period.

After a programmed number of consecutive missed periods, a timer emits a one-cycle non-maskable-interrupt request. It emits a one-cycle reset request after a second, separately programmed number. Each request also latches a sticky status flag, which software clears by writing 1 to it. All configuration and observation goes through a single-cycle write port and a combinational read port on the same address bus. What happens downstream of the two request outputs belongs to other blocks.

Top module: `hb_watchdog`

## Requirements
- R1: After a synchronous active-low reset, the control word, status word, every count, maximum, mask and heartbeat register read 0, and both request outputs are low.
- R2: While its enable is set, a timer's count falls by one per cycle and reloads from the maximum on the cycle after it reads 0, so wraps are maximum+1 cycles apart. Writing the maximum loads both the maximum and the count on the same edge.
- R3: While its enable bit is clear, a timer's count holds its value and no wrap occurs.
- R4: A heartbeat write of index k = 32*node + 4*core + thread sets heartbeat bit k when mask bit k is set. Indices 0..63 sit in the low mask/heartbeat word, with node 0 in bits 31:0 and node 1 in bits 63:32. Indices 64..127 sit in the high word at bit k-64.
- R5: A heartbeat write whose index is not set in the mask, or whose value is 128 or more, changes no heartbeat bit.
- R6: A wrap at which every masked heartbeat bit is set clears all heartbeat bits and the missed-period count, and raises no request.
- R7: A wrap at which some masked heartbeat bit is clear raises the missed-period count by one, saturating at 3, and leaves the heartbeat bits unchanged.
- R8: Timer i emits a one-cycle NMI request on the edge at which its missed-period count first becomes equal to the NMI threshold in control bits [2+2i+1:2+2i]. A threshold of 0 never fires.
- R9: Timer i emits a one-cycle reset request on the edge at which its missed-period count first becomes equal to the reset threshold in control bits [6+2i+1:6+2i]. A threshold of 0 never fires.
- R10: Control bit i enables timer i. Status bit i is set by timer i's reset request and status bit 2+i by its NMI request. Writing 1 to a status bit clears it, and a new request on the same edge wins.
- R11: Word addresses: control 0, status 1. Timer i occupies base 8*(i+1), with these offsets: 0 maximum, 1 count (read only), 2 mask low, 3 mask high, 4 heartbeat command (write only, reads 0), 5 heartbeats low, 6 heartbeats high (read only). Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 6 | Word address for both writes and reads |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Combinational read data for `addr` |
| nmi_req | output | 2 | One-cycle NMI request per timer |
| rst_req | output | 2 | One-cycle reset request per timer |

## Verification
The assertions assume that reset is held low through the first clock edge and that `wr_en` is never unknown after reset. They also assume the count only jumps when a maximum write is present, which they take from the decoded write strobe rather than from the address bus. The stimulus writes one register per cycle, places heartbeats well away from wrap edges, and programs each timer's maximum and mask before enabling it, so the expected request cycles follow directly from the enable edge and the period. Heartbeat indices are chosen so that a truncated index check would alias onto a masked bit and become visible.

// File: rtl/hbwd_pkg.sv
// Shared register offsets and field widths for the dual heartbeat watchdog.
// Assumes: word addressing; each timer owns an 8-word window.
package hbwd_pkg;

    typedef enum logic [2:0] {
        OFF_MAX      = 3'd0,
        OFF_CNT      = 3'd1,
        OFF_MASK_LO  = 3'd2,
        OFF_MASK_HI  = 3'd3,
        OFF_BEAT_CMD = 3'd4,
        OFF_BEAT_LO  = 3'd5,
        OFF_BEAT_HI  = 3'd6,
        OFF_RSVD     = 3'd7
    } hbwd_off_e;

    localparam int unsigned HBWD_CTRL_ADDR = 0;
    localparam int unsigned HBWD_STAT_ADDR = 1;
    localparam int unsigned HBWD_OFF_W     = 3;
    localparam int unsigned HBWD_THR_W     = 2;

endpackage

// File: rtl/hbwd_csr.sv
// Control and status registers shared by all timers.
// Control layout: enables in [NUM_WD-1:0], NMI thresholds (2 bits each) from
// bit NUM_WD, reset thresholds (2 bits each) from bit 3*NUM_WD.
// Status layout: reset flags in [NUM_WD-1:0], NMI flags from bit NUM_WD.
// Assumes: write data is presented only for the bits the layout uses.
module hbwd_csr
    import hbwd_pkg::*;
#(
    parameter int NUM_WD = 2,
    parameter int ADDR_W = 6
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [ADDR_W-1:0]                    addr,
    input  logic [5*NUM_WD-1:0]                  wdata_lo,
    input  logic [NUM_WD-1:0]                    nmi_evt,
    input  logic [NUM_WD-1:0]                    rst_evt,
    output logic [5*NUM_WD-1:0]                  ctrl_q,
    output logic [2*NUM_WD-1:0]                  status_q,
    output logic [NUM_WD-1:0]                    wd_en,
    output logic [NUM_WD-1:0][HBWD_THR_W-1:0]    nmi_thr,
    output logic [NUM_WD-1:0][HBWD_THR_W-1:0]    rst_thr
);

    localparam int CTRL_W = 5 * NUM_WD;
    localparam int STAT_W = 2 * NUM_WD;

    logic ctrl_wr;
    logic stat_wr;
    logic [STAT_W-1:0] clr_mask;

    // Decode the two shared register addresses.
    always_comb begin
        ctrl_wr  = wr_en && (addr == ADDR_W'(HBWD_CTRL_ADDR));
        stat_wr  = wr_en && (addr == ADDR_W'(HBWD_STAT_ADDR));
        clr_mask = stat_wr ? wdata_lo[STAT_W-1:0] : '0;
    end

    // Control register: plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= wdata_lo[CTRL_W-1:0];
    end

    // Status register: write-one-to-clear, new events take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask) | {nmi_evt, rst_evt};
    end

    // Slice per-timer fields out of the control word.
    for (genvar i = 0; i < NUM_WD; i++) begin : g_fields
        assign wd_en[i]   = ctrl_q[i];
        assign nmi_thr[i] = ctrl_q[NUM_WD + HBWD_THR_W*i +: HBWD_THR_W];
        assign rst_thr[i] = ctrl_q[3*NUM_WD + HBWD_THR_W*i +: HBWD_THR_W];
    end

endmodule

// File: rtl/hbwd_beat_track.sv
// Participation mask and heartbeat collection for one timer.
// A heartbeat write sets one bit if the index is in range and masked.
// Assumes: MASK_W == 2*DATA_W (mask split into a low and a high word).
module hbwd_beat_track #(
    parameter int DATA_W = 64,
    parameter int MASK_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_lo_wr,
    input  logic              mask_hi_wr,
    input  logic              beat_wr,
    input  logic              beat_clr,
    input  logic [DATA_W-1:0] wdata,
    output logic [MASK_W-1:0] mask_q,
    output logic [MASK_W-1:0] beat_q,
    output logic              all_beaten
);

    localparam int IDX_W = $clog2(MASK_W);
    localparam int HI_W  = MASK_W - DATA_W;

    logic [IDX_W-1:0]  idx;
    logic              in_range;
    logic [MASK_W-1:0] set_vec;

    // Turn a heartbeat command into a one-hot set vector gated by the mask.
    always_comb begin
        idx        = wdata[IDX_W-1:0];
        in_range   = (wdata[DATA_W-1:IDX_W] == '0);
        set_vec    = (beat_wr && in_range) ? ((MASK_W'(1) << idx) & mask_q) : '0;
        all_beaten = ((beat_q & mask_q) == mask_q);
    end

    // Mask words written independently.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            if (mask_lo_wr) mask_q[DATA_W-1:0]      <= wdata;
            if (mask_hi_wr) mask_q[MASK_W-1:DATA_W] <= wdata[HI_W-1:0];
        end
    end

    // Heartbeat bits: clear on a satisfied wrap, a same-edge beat survives.
    always_ff @(posedge clk) begin
        if (!rst_n) beat_q <= '0;
        else        beat_q <= (beat_clr ? '0 : beat_q) | set_vec;
    end

endmodule

// File: rtl/hbwd_channel.sv
// One watchdog timer: down-counter with reload, missed-period tracking and
// threshold detection for the NMI and reset requests.
// Assumes: thresholds are 2 bits; 0 disables the corresponding request.
module hbwd_channel
    import hbwd_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 64,
    parameter int MASK_W = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic [HBWD_THR_W-1:0] nmi_thr,
    input  logic [HBWD_THR_W-1:0] rst_thr,
    input  logic                  max_wr,
    input  logic                  mask_lo_wr,
    input  logic                  mask_hi_wr,
    input  logic                  beat_wr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [CNT_W-1:0]      cnt_q,
    output logic [CNT_W-1:0]      max_q,
    output logic [MASK_W-1:0]     mask_q,
    output logic [MASK_W-1:0]     beat_q,
    output logic                  nmi_evt,
    output logic                  rst_evt,
    output logic                  nmi_pulse,
    output logic                  rst_pulse
);

    localparam logic [HBWD_THR_W-1:0] MISS_SAT = '1;

    logic                  wrap;
    logic                  all_beaten;
    logic                  missed;
    logic [HBWD_THR_W-1:0] miss_q;
    logic [HBWD_THR_W-1:0] miss_inc;

    hbwd_beat_track #(
        .DATA_W (DATA_W),
        .MASK_W (MASK_W)
    ) u_beats (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_lo_wr (mask_lo_wr),
        .mask_hi_wr (mask_hi_wr),
        .beat_wr    (beat_wr),
        .beat_clr   (wrap && all_beaten),
        .wdata      (wdata),
        .mask_q     (mask_q),
        .beat_q     (beat_q),
        .all_beaten (all_beaten)
    );

    // Wrap detection and threshold crossing for this cycle.
    always_comb begin
        wrap     = enable && (cnt_q == '0);
        missed   = wrap && !all_beaten;
        miss_inc = (miss_q == MISS_SAT) ? miss_q : miss_q + 1'b1;
        nmi_evt  = missed && (nmi_thr != '0) && (miss_inc == nmi_thr) && (miss_q != nmi_thr);
        rst_evt  = missed && (rst_thr != '0) && (miss_inc == rst_thr) && (miss_q != rst_thr);
    end

    // Maximum register and down-counter with reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_q <= '0;
            cnt_q <= '0;
        end else if (max_wr) begin
            max_q <= wdata[CNT_W-1:0];
            cnt_q <= wdata[CNT_W-1:0];
        end else if (enable) begin
            cnt_q <= wrap ? max_q : cnt_q - 1'b1;
        end
    end

    // Missed-period counter, updated only at wraps.
    always_ff @(posedge clk) begin
        if (!rst_n)          miss_q <= '0;
        else if (wrap)       miss_q <= all_beaten ? '0 : miss_inc;
    end

    // Registered one-cycle request outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_pulse <= 1'b0;
            rst_pulse <= 1'b0;
        end else begin
            nmi_pulse <= nmi_evt;
            rst_pulse <= rst_evt;
        end
    end

endmodule

// File: rtl/hb_watchdog.sv
// Top of the dual heartbeat watchdog: address decode, per-timer instances
// and the read multiplexer.
// Assumes: ADDR_W leaves room for NUM_WD+1 windows of 8 words.
module hb_watchdog
    import hbwd_pkg::*;
#(
    parameter int NUM_WD           = 2,
    parameter int NODES            = 4,
    parameter int THREADS_PER_NODE = 32,
    parameter int CNT_W            = 32,
    parameter int DATA_W           = 64,
    parameter int ADDR_W           = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_WD-1:0] nmi_req,
    output logic [NUM_WD-1:0] rst_req
);

    localparam int MASK_W  = NODES * THREADS_PER_NODE;
    localparam int SEL_W   = ADDR_W - HBWD_OFF_W;

    logic [5*NUM_WD-1:0]                ctrl_q;
    logic [2*NUM_WD-1:0]                status_q;
    logic [NUM_WD-1:0]                  wd_en;
    logic [NUM_WD-1:0][HBWD_THR_W-1:0]  nmi_thr;
    logic [NUM_WD-1:0][HBWD_THR_W-1:0]  rst_thr;
    logic [NUM_WD-1:0]                  nmi_evt;
    logic [NUM_WD-1:0]                  rst_evt;
    logic [NUM_WD-1:0]                  max_wr;
    logic [NUM_WD-1:0]                  mlo_wr;
    logic [NUM_WD-1:0]                  mhi_wr;
    logic [NUM_WD-1:0]                  beat_wr;
    logic [NUM_WD-1:0][CNT_W-1:0]       cnt_all;
    logic [NUM_WD-1:0][CNT_W-1:0]       max_all;
    logic [NUM_WD-1:0][MASK_W-1:0]      mask_all;
    logic [NUM_WD-1:0][MASK_W-1:0]      beat_all;
    logic [SEL_W-1:0]                   win_sel;
    hbwd_off_e                          off;

    // Split the address into window select and offset.
    always_comb begin
        win_sel = addr[ADDR_W-1:HBWD_OFF_W];
        off     = hbwd_off_e'(addr[HBWD_OFF_W-1:0]);
    end

    hbwd_csr #(
        .NUM_WD (NUM_WD),
        .ADDR_W (ADDR_W)
    ) u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata_lo (wdata[5*NUM_WD-1:0]),
        .nmi_evt  (nmi_evt),
        .rst_evt  (rst_evt),
        .ctrl_q   (ctrl_q),
        .status_q (status_q),
        .wd_en    (wd_en),
        .nmi_thr  (nmi_thr),
        .rst_thr  (rst_thr)
    );

    for (genvar i = 0; i < NUM_WD; i++) begin : g_wd
        logic hit;

        // Per-timer write strobes from the decoded window.
        always_comb begin
            hit       = wr_en && (win_sel == SEL_W'(i + 1));
            max_wr[i] = hit && (off == OFF_MAX);
            mlo_wr[i] = hit && (off == OFF_MASK_LO);
            mhi_wr[i] = hit && (off == OFF_MASK_HI);
            beat_wr[i]= hit && (off == OFF_BEAT_CMD);
        end

        hbwd_channel #(
            .CNT_W  (CNT_W),
            .DATA_W (DATA_W),
            .MASK_W (MASK_W)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .enable     (wd_en[i]),
            .nmi_thr    (nmi_thr[i]),
            .rst_thr    (rst_thr[i]),
            .max_wr     (max_wr[i]),
            .mask_lo_wr (mlo_wr[i]),
            .mask_hi_wr (mhi_wr[i]),
            .beat_wr    (beat_wr[i]),
            .wdata      (wdata),
            .cnt_q      (cnt_all[i]),
            .max_q      (max_all[i]),
            .mask_q     (mask_all[i]),
            .beat_q     (beat_all[i]),
            .nmi_evt    (nmi_evt[i]),
            .rst_evt    (rst_evt[i]),
            .nmi_pulse  (nmi_req[i]),
            .rst_pulse  (rst_req[i])
        );
    end

    // Combinational read multiplexer over shared and per-timer registers.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(HBWD_CTRL_ADDR)) begin
            rdata = DATA_W'(ctrl_q);
        end else if (addr == ADDR_W'(HBWD_STAT_ADDR)) begin
            rdata = DATA_W'(status_q);
        end else begin
            for (int i = 0; i < NUM_WD; i++) begin
                if (win_sel == SEL_W'(i + 1)) begin
                    case (off)
                        OFF_MAX:     rdata = DATA_W'(max_all[i]);
                        OFF_CNT:     rdata = DATA_W'(cnt_all[i]);
                        OFF_MASK_LO: rdata = mask_all[i][DATA_W-1:0];
                        OFF_MASK_HI: rdata = DATA_W'(mask_all[i][MASK_W-1:DATA_W]);
                        OFF_BEAT_LO: rdata = beat_all[i][DATA_W-1:0];
                        OFF_BEAT_HI: rdata = DATA_W'(beat_all[i][MASK_W-1:DATA_W]);
                        default:     rdata = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/hbwd_chk.sv
// Property checker for hb_watchdog, attached by bind below.
// Assumes: reset is asserted across the first clock edge.
module hbwd_chk #(
    parameter int NUM_WD = 2,
    parameter int CNT_W  = 32,
    parameter int MASK_W = 128
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_WD-1:0]              wd_en,
    input logic [NUM_WD-1:0]              max_wr,
    input logic [NUM_WD-1:0][CNT_W-1:0]   cnt_all,
    input logic [NUM_WD-1:0][MASK_W-1:0]  mask_all,
    input logic [NUM_WD-1:0][MASK_W-1:0]  beat_all,
    input logic [NUM_WD-1:0]              nmi_req,
    input logic [NUM_WD-1:0]              rst_req,
    input logic [2*NUM_WD-1:0]            status_q
);

    for (genvar i = 0; i < NUM_WD; i++) begin : g_chk
        // R2
        cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wd_en[i] && (cnt_all[i] != '0) && !max_wr[i]) |=> (cnt_all[i] == $past(cnt_all[i]) - 1'b1));
        // R3
        cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!wd_en[i] && !max_wr[i]) |=> $stable(cnt_all[i]));
        // R5
        beat_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((beat_all[i] & ~$past(beat_all[i]) & ~$past(mask_all[i])) == '0));
        // R8
        nmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            nmi_req[i] |=> !nmi_req[i]);
        // R8
        nmi_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
            nmi_req[i] |-> $past(wd_en[i]));
        // R9
        rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_req[i] |=> !rst_req[i]);
        // R10
        nmi_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            nmi_req[i] |-> status_q[NUM_WD + i]);
        // R10
        rst_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_req[i] |-> status_q[i]);
    end

endmodule

bind hb_watchdog hbwd_chk #(
    .NUM_WD (NUM_WD),
    .CNT_W  (CNT_W),
    .MASK_W (MASK_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wd_en    (wd_en),
    .max_wr   (max_wr),
    .cnt_all  (cnt_all),
    .mask_all (mask_all),
    .beat_all (beat_all),
    .nmi_req  (nmi_req),
    .rst_req  (rst_req),
    .status_q (status_q)
);

// File: tb/sim_hb_watchdog.sv
// Scoreboard bench: the driver queues expected requests with their cycle,
// a monitor pops and compares them as the requests appear.
module sim_hb_watchdog;

    localparam int NUM_WD = 2;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic [NUM_WD-1:0] nmi_req;
    logic [NUM_WD-1:0] rst_req;

    typedef struct {
        int     wd;
        int     kind;   // 0 = NMI, 1 = reset
        longint cyc;
    } exp_t;

    exp_t   exp_q[$];
    longint cyc = 0;
    int     n_cmp = 0;
    int     n_bad = 0;
    bit     done = 1'b0;

    hb_watchdog u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .nmi_req (nmi_req),
        .rst_req (rst_req)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    task automatic wr(input int a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = ADDR_W'(a);
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        wdata = '0;
    endtask

    task automatic rd(input int a, output logic [63:0] d);
        addr = ADDR_W'(a);
        #1;
        d = rdata;
    endtask

    task automatic wait_until(input longint c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic expect_req(input int wd, input int kind, input longint c);
        exp_t e;
        e.wd = wd; e.kind = kind; e.cyc = c;
        exp_q.push_back(e);
    endtask

    // Monitor: every request pulse must match the head of the queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int w = 0; w < NUM_WD; w++) begin
                for (int k = 0; k < 2; k++) begin
                    if ((k == 0) ? nmi_req[w] : rst_req[w]) begin
                        n_cmp++;
                        if (exp_q.size() == 0) begin
                            n_bad++;
                            $display("FAIL %s: unexpected request wd%0d at cycle %0d, expected none",
                                     (k == 0) ? "R8" : "R9", w, cyc);
                        end else begin
                            exp_t e;
                            e = exp_q.pop_front();
                            if (e.wd != w || e.kind != k || e.cyc != cyc) begin
                                n_bad++;
                                $display("FAIL %s: actual wd%0d kind%0d cycle %0d expected wd%0d kind%0d cycle %0d",
                                         (e.kind == 0) ? "R8" : "R9", w, k, cyc, e.wd, e.kind, e.cyc);
                            end
                        end
                    end
                end
            end
        end
    end

    // Watchdog for a hung run.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        longint e0, e1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(0, v);  check("R1 ctrl", v, 64'd0);
        rd(1, v);  check("R1 status", v, 64'd0);
        rd(9, v);  check("R1 wd0 count", v, 64'd0);
        rd(21, v); check("R1 wd1 beats low", v, 64'd0);
        check("R1 requests", {62'd0, nmi_req | rst_req}, 64'd0);
        rd(7, v);  check("R11 unmapped", v, 64'd0);

        // Timer 0: period 10, threads 0 and 37, NMI after 1 miss, reset after 2
        wr(8, 64'd9);
        rd(9, v);  check("R2 max write loads count", v, 64'd9);
        wr(10, (64'd1 << 0) | (64'd1 << 37));
        rd(10, v); check("R4 mask low readback", v, (64'd1 << 0) | (64'd1 << 37));
        rd(9, v);  check("R3 disabled count holds", v, 64'd9);
        wr(0, 64'd1 | (64'd1 << 2) | (64'd2 << 6));
        e0 = cyc;
        expect_req(0, 0, e0 + 10);
        expect_req(0, 1, e0 + 20);
        wait_until(e0 + 3);
        rd(9, v);  check("R2 count falls", v, 64'd6);
        wait_until(e0 + 31);
        rd(1, v);  check("R10 status after timer0 requests", v, 64'h5);
        wr(1, 64'h4);
        rd(1, v);  check("R10 write-one clears NMI flag", v, 64'h1);
        wr(0, 64'd0);
        rd(9, v);
        repeat (5) @(negedge clk);
        begin
            logic [63:0] v2;
            rd(9, v2); check("R3 count holds after disable", v2, v);
        end

        // Timer 1: period 20, threads 5 and 100, NMI after 1 miss, reset after 3
        wr(16, 64'd19);
        wr(18, 64'd1 << 5);
        wr(19, 64'd1 << 36);
        wr(0, 64'd2 | (64'd1 << 4) | (64'd3 << 8));
        e1 = cyc;
        expect_req(1, 0, e1 + 40);
        expect_req(1, 1, e1 + 80);
        expect_req(1, 0, e1 + 140);
        wr(20, 64'd5);
        rd(21, v); check("R4 beat index 5", v, 64'd1 << 5);
        wr(20, 64'd6);
        rd(21, v); check("R5 unmasked index ignored", v, 64'd1 << 5);
        wr(20, 64'd228);
        rd(22, v); check("R5 index over 127 ignored", v, 64'd0);
        wr(20, 64'd100);
        rd(22, v); check("R4 beat index 100 in high word", v, 64'd1 << 36);
        wait_until(e1 + 21);
        rd(21, v); check("R6 beats cleared low", v, 64'd0);
        rd(22, v); check("R6 beats cleared high", v, 64'd0);
        rd(1, v);  check("R6 no new status", v, 64'h1);
        wr(20, 64'd5);
        wait_until(e1 + 41);
        rd(21, v); check("R7 beats held on miss", v, 64'd1 << 5);
        rd(1, v);  check("R10 NMI flag timer1", v, 64'h9);
        wait_until(e1 + 101);
        rd(1, v);  check("R9 reset flag timer1", v, 64'hB);
        wr(20, 64'd100);
        wait_until(e1 + 121);
        rd(21, v); check("R6 satisfied wrap clears low", v, 64'd0);
        wr(1, 64'hF);
        rd(1, v);  check("R10 clear all flags", v, 64'h0);
        wait_until(e1 + 141);
        rd(1, v);  check("R7 miss count restarted, NMI again", v, 64'h8);
        wr(16, 64'd50);
        rd(17, v); check("R2 max write reloads running count", v, 64'd50);
        wr(0, 64'd0);
        repeat (5) @(negedge clk);
        check("R8 R9 all expected requests seen", 64'(exp_q.size()), 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule